// File: doc/BRIEF.md
# Serial Converter Host Transaction Engine

This block is the host end of a four-wire synchronous serial link to a 12-bit successive-approximation converter. A client hands it an 8-bit control byte over a valid/ready handshake. The engine lowers chip select and generates the serial clock from the system clock. The low and high phases of that clock have separate programmable lengths. The engine shifts the control byte out and collects the 12-bit conversion result from the converter's data-out line. It then returns the result with a one-cycle done strobe.

Two frame shapes are supported. In the plain frame each conversion takes 24 serial clocks: the control byte, one clock while the converter samples, twelve result bits, and three zero bits that are discarded. In the overlapped frame the next control byte goes out on clocks 17 to 24 of the current conversion, while the last result bits are still arriving. Back-to-back conversions therefore need 16 serial clocks each, and chip select stays low between them. An optional watchdog counts how long the converter's busy flag stays high and raises a one-cycle error pulse if it exceeds a programmed number of serial clocks.

Top module: `sah_host`

## Requirements
- R1: Out of reset and between frames, chip select is high, the serial clock is low, data-in is low, and req_ready is high.
- R2: An accepted request lowers cs_n on the next cycle. In the plain frame cs_n stays low for exactly 24 serial clocks and rises in the cycle after the 24th high phase ends.
- R3: Every serial clock low phase lasts cfg_lo_cycles system cycles and every high phase lasts cfg_hi_cycles; a value of 0 counts as 1. The first low phase after cs_n falls is the select-to-clock setup time.
- R4: mosi carries the control byte MSB first on clocks 1 to 8. It is 0 on every later clock of a conversion, and it changes only in the cycle that starts a low phase.
- R5: Result bits 11 down to 0 are taken from miso at the rising edges of clocks 10 to 21 of their conversion. miso on clocks 1 to 9 and 22 to 24 has no effect on the result.
- R6: res_valid is high for exactly one cycle, the first high cycle of clock 21. In that cycle res_data holds the 12-bit result.
- R7: With cfg_overlap set and a request valid, req_ready is high in the last cycle of clock 16's high phase. The new control byte's MSB then appears on the next clock without cs_n rising. The previous result completes on clock 5 of the new conversion, with res_valid in that clock's first high cycle.
- R8: With cfg_overlap set and no request pending at clock 16, the frame runs its full 24 clocks and cs_n rises.
- R9: With cfg_busy_chk set, busy_in is sampled at each rising edge from clock 9 on, until the first low sample. If cfg_busy_limit consecutive high samples occur, timeout_err pulses for one cycle in the first high cycle of clock 8+cfg_busy_limit. With the check disabled, or with a limit of 0, it never pulses.
- R10: req_ready is low at every other point of a frame, so a request held valid during a frame is not taken until the engine is idle or at the overlap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Control byte offered |
| req_ready | output | 1 | Engine takes the byte this cycle |
| req_cmd | input | CMD_W (8) | Control byte, bit 7 first on the wire |
| cfg_lo_cycles | input | DIV_W (8) | System cycles per serial clock low phase |
| cfg_hi_cycles | input | DIV_W (8) | System cycles per serial clock high phase |
| cfg_overlap | input | 1 | Enable 16-clock overlapped conversions |
| cfg_busy_chk | input | 1 | Enable busy watchdog |
| cfg_busy_limit | input | LIM_W (8) | Busy high samples that raise an error |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to converter |
| miso | input | 1 | Serial data from converter |
| busy_in | input | 1 | Converter busy flag |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_W (12) | Conversion result |
| timeout_err | output | 1 | One-cycle busy timeout pulse |

## Verification
A slot counter that is off by one shows at once on mosi: the control bits shift to the wrong clock. It also moves the res_valid strobe away from clock 21, which the per-cycle comparison flags within one serial clock. A wrong phase counter changes the length of the very next sclk level. If the overlap tail flag is not set, the previous result loses its last five bits. If it is not cleared, a corrupted value and an extra strobe appear within five serial clocks of the new conversion. A broken busy counter shows as a missing or early timeout pulse inside the same conversion.

// File: rtl/sah_pkg.sv
`timescale 1ns/1ps
package sah_pkg;
    // serial clock level the engine is currently holding
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // a plain frame is three bytes long, an overlapped conversion two
    localparam int unsigned FRAME_BYTES = 3;
    localparam int unsigned OVL_BYTES   = 2;
endpackage

// File: rtl/sah_rx_shift.sv
`timescale 1ns/1ps
module sah_rx_shift #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic             done,
    input  logic             bit_in,
    output logic             valid,
    output logic [RES_W-1:0] data
);
    typedef struct packed {
        logic [RES_W-1:0] sh;
        logic [RES_W-1:0] data;
        logic             valid;
    } rx_t;

    rx_t rx_q, rx_d;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = done;
        if (cap) begin
            rx_d.sh = {rx_q.sh[RES_W-2:0], bit_in};
        end
        if (done) begin
            rx_d.data = {rx_q.sh[RES_W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '{sh: '0, data: '0, valid: 1'b0};
        end else begin
            rx_q <= rx_d;
        end
    end

    assign valid = rx_q.valid;
    assign data  = rx_q.data;
endmodule

// File: rtl/sah_busy_watch.sv
`timescale 1ns/1ps
module sah_busy_watch #(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sample,
    input  logic             busy_in,
    input  logic             enable,
    input  logic [LIM_W-1:0] limit,
    output logic             err
);
    typedef struct packed {
        logic [LIM_W-1:0] cnt;
        logic             stop;
        logic             err;
    } bw_t;

    bw_t bw_q, bw_d;
    logic [LIM_W-1:0] cnt_inc;

    always_comb begin
        bw_d     = bw_q;
        bw_d.err = 1'b0;
        cnt_inc  = bw_q.cnt + LIM_W'(1);
        if (start) begin
            bw_d.cnt  = '0;
            bw_d.stop = 1'b0;
        end else if (sample && !bw_q.stop) begin
            if (busy_in) begin
                bw_d.cnt = cnt_inc;
                if (enable && (limit != '0) && (cnt_inc == limit)) begin
                    bw_d.err  = 1'b1;
                    bw_d.stop = 1'b1;
                end
            end else begin
                bw_d.stop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bw_q <= '{cnt: '0, stop: 1'b1, err: 1'b0};
        end else begin
            bw_q <= bw_d;
        end
    end

    assign err = bw_q.err;
endmodule

// File: rtl/sah_host.sv
`timescale 1ns/1ps
module sah_host
    import sah_pkg::*;
#(
    parameter int CMD_W = 8,
    parameter int RES_W = 12,
    parameter int DIV_W = 8,
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [CMD_W-1:0] req_cmd,
    input  logic [DIV_W-1:0] cfg_lo_cycles,
    input  logic [DIV_W-1:0] cfg_hi_cycles,
    input  logic             cfg_overlap,
    input  logic             cfg_busy_chk,
    input  logic [LIM_W-1:0] cfg_busy_limit,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    input  logic             busy_in,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic             timeout_err
);
    localparam int FRAME_CLKS = FRAME_BYTES * CMD_W;
    localparam int OVL_CLKS   = OVL_BYTES * CMD_W;
    localparam int RES_FIRST  = CMD_W + 1;
    localparam int RES_LAST   = RES_FIRST + RES_W - 1;
    localparam int TAIL_LAST  = RES_LAST - OVL_CLKS;
    localparam int SLOT_W     = $clog2(FRAME_CLKS);

    localparam logic [SLOT_W-1:0] SL_LAST      = SLOT_W'(FRAME_CLKS - 1);
    localparam logic [SLOT_W-1:0] SL_OVL       = SLOT_W'(OVL_CLKS - 1);
    localparam logic [SLOT_W-1:0] SL_RES_FIRST = SLOT_W'(RES_FIRST);
    localparam logic [SLOT_W-1:0] SL_RES_LAST  = SLOT_W'(RES_LAST);
    localparam logic [SLOT_W-1:0] SL_TAIL_LAST = SLOT_W'(TAIL_LAST);
    localparam logic [SLOT_W-1:0] SL_BUSY      = SLOT_W'(CMD_W);

    typedef struct packed {
        phase_e            ph;
        logic [DIV_W-1:0]  cnt;
        logic [SLOT_W-1:0] slot;
        logic [CMD_W-1:0]  cmd;
        logic              tail;
    } ctl_t;

    ctl_t q, d;

    logic [DIV_W-1:0] lo_m1, hi_m1;
    logic             last_hi, ovl_pt, accept, rise;
    logic             cap, done, busy_smp;

    always_comb begin
        lo_m1   = (cfg_lo_cycles == '0) ? '0 : cfg_lo_cycles - DIV_W'(1);
        hi_m1   = (cfg_hi_cycles == '0) ? '0 : cfg_hi_cycles - DIV_W'(1);
        last_hi = (q.ph == PH_HIGH) && (q.cnt == '0);
        ovl_pt  = last_hi && (q.slot == SL_OVL) && cfg_overlap;
        req_ready = (q.ph == PH_IDLE) || ovl_pt;
        accept  = req_valid && req_ready;
        rise    = (q.ph == PH_LOW) && (q.cnt == '0);

        d = q;
        unique case (q.ph)
            PH_IDLE: begin
                if (accept) begin
                    d.ph   = PH_LOW;
                    d.cnt  = lo_m1;
                    d.slot = '0;
                    d.cmd  = req_cmd;
                    d.tail = 1'b0;
                end
            end
            PH_LOW: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_HIGH;
                    d.cnt = hi_m1;
                    if (q.tail && (q.slot == SL_TAIL_LAST)) begin
                        d.tail = 1'b0;
                    end
                end else begin
                    d.cnt = q.cnt - DIV_W'(1);
                end
            end
            PH_HIGH: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - DIV_W'(1);
                end else if (accept) begin
                    d.ph   = PH_LOW;
                    d.cnt  = lo_m1;
                    d.slot = '0;
                    d.cmd  = req_cmd;
                    d.tail = 1'b1;
                end else if (q.slot == SL_LAST) begin
                    d.ph   = PH_IDLE;
                    d.cnt  = '0;
                    d.slot = '0;
                    d.cmd  = '0;
                    d.tail = 1'b0;
                end else begin
                    d.ph   = PH_LOW;
                    d.cnt  = lo_m1;
                    d.slot = q.slot + SLOT_W'(1);
                    d.cmd  = {q.cmd[CMD_W-2:0], 1'b0};
                end
            end
            default: d.ph = PH_IDLE;
        endcase

        cap = rise && (((q.slot >= SL_RES_FIRST) && (q.slot <= SL_RES_LAST)) ||
                       (q.tail && (q.slot <= SL_TAIL_LAST)));
        done = rise && ((q.slot == SL_RES_LAST) ||
                        (q.tail && (q.slot == SL_TAIL_LAST)));
        busy_smp = rise && (q.slot >= SL_BUSY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, cnt: '0, slot: '0, cmd: '0, tail: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign cs_n = (q.ph == PH_IDLE);
    assign sclk = (q.ph == PH_HIGH);
    assign mosi = q.cmd[CMD_W-1];

    sah_rx_shift #(.RES_W(RES_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap),
        .done   (done),
        .bit_in (miso),
        .valid  (res_valid),
        .data   (res_data)
    );

    sah_busy_watch #(.LIM_W(LIM_W)) u_bw (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .sample  (busy_smp),
        .busy_in (busy_in),
        .enable  (cfg_busy_chk),
        .limit   (cfg_busy_limit),
        .err     (timeout_err)
    );
endmodule

// File: rtl/sah_host_chk.sv
`timescale 1ns/1ps
module sah_host_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic cfg_overlap,
    input logic cfg_busy_chk,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic res_valid,
    input logic timeout_err
);
    // R1
    idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sclk && !mosi));

    // R2
    select_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cs_n) |=> (!cs_n && !sclk));

    // R3
    clock_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R6
    done_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (sclk && !cs_n));

    // R9
    timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> !timeout_err);

    // R9
    timeout_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> $past(cfg_busy_chk));

    // R10
    ready_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !cs_n) |-> (sclk && cfg_overlap));
endmodule

bind sah_host sah_host_chk u_chk (.*);

// File: tb/sim_sah_host.sv
`timescale 1ns/1ps
module sim_sah_host;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic       req_ready;
    logic [7:0] req_cmd;
    logic [7:0] lo, hi, lim;
    logic       ovl, chk_en;
    logic       cs_n, sclk, mosi;
    logic       miso, busy_in;
    logic       res_valid;
    logic [11:0] res_data;
    logic       timeout_err;

    int errors = 0;
    int checks = 0;
    int busy_len = 2;
    bit finished = 0;

    always #10 clk = ~clk;

    sah_host u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .cfg_lo_cycles(lo), .cfg_hi_cycles(hi),
        .cfg_overlap(ovl), .cfg_busy_chk(chk_en), .cfg_busy_limit(lim),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso), .busy_in(busy_in),
        .res_valid(res_valid), .res_data(res_data), .timeout_err(timeout_err)
    );

    task automatic cmp(input logic a, input logic e, input string tag);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, a, e, $time);
        end
    endtask

    task automatic cmp_int(input int a, input int e, input string tag);
        checks++;
        if (a != e) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
        end
    endtask

    task automatic expect_cycle(input logic e_cs, input logic e_sc, input logic e_mo,
                                input logic e_rdy, input logic e_rv, input logic e_er);
        cmp(cs_n, e_cs, e_cs ? "R1 idle chip select" : "R2 chip select");
        cmp(sclk, e_sc, "R3 serial clock level");
        cmp(mosi, e_mo, "R4 data-in bit");
        cmp(req_ready, e_rdy, "R10 request ready");
        cmp(res_valid, e_rv, "R6 done strobe");
        cmp(timeout_err, e_er, "R9 timeout pulse");
    endtask

    // request driver
    logic [7:0] cmdq[$];
    initial begin
        bit hs;
        req_valid = 1'b0;
        req_cmd   = 8'h00;
        forever begin
            @(negedge clk);
            hs = req_valid && req_ready;
            @(posedge clk);
            #1;
            if (hs) void'(cmdq.pop_front());
            if (cmdq.size() > 0) begin
                req_valid = 1'b1;
                req_cmd   = cmdq[0];
            end else begin
                req_valid = 1'b0;
            end
        end
    end

    // converter model
    int expq[$];
    int gs, rx, cur_o, cur_v, prev_o, prev_v, nconv;
    logic psclk;

    function automatic int val_for(input int n);
        if (n == 0) return 'hFFF;
        if (n == 1) return 'h001;
        return (n * 'h2C9 + 'h5A3) & 'hFFF;
    endfunction

    function automatic logic bit_for(input int o, input int v, input int s);
        int k;
        k = s - (o + 9);
        if (k >= 0 && k < 12) return logic'((v >> (11 - k)) & 1);
        return 1'b0;
    endfunction

    function automatic logic busy_for(input int o, input int s);
        return (s >= o + 8) && (s < o + 8 + busy_len);
    endfunction

    initial begin
        miso = 1'b0; busy_in = 1'b0; psclk = 1'b0;
        gs = -1; rx = 0; cur_o = -100; prev_o = -100; cur_v = 0; prev_v = 0; nconv = 0;
        forever begin
            @(negedge clk);
            if (cs_n !== 1'b0) begin
                gs = -1; rx = 0; cur_o = -100; prev_o = -100;
                miso = 1'b0; busy_in = 1'b0; psclk = 1'b0;
            end else begin
                if (sclk && !psclk) begin
                    gs++;
                    if (rx > 0) rx--;
                    else if (mosi) begin
                        prev_o = cur_o; prev_v = cur_v;
                        cur_o = gs; cur_v = val_for(nconv); nconv++;
                        expq.push_back(cur_v);
                        rx = 7;
                    end
                end
                if (!sclk && psclk) begin
                    miso    = bit_for(cur_o, cur_v, gs + 1) | bit_for(prev_o, prev_v, gs + 1);
                    busy_in = busy_for(cur_o, gs + 1) | busy_for(prev_o, gs + 1);
                end
                psclk = sclk;
            end
        end
    end

    // result data (R5) and per-run counters
    int cs_low_cnt = 0, rise_cnt = 0, err_cnt = 0;
    logic pcs = 1'b1;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (!cs_n) cs_low_cnt++;
            if (cs_n && !pcs) rise_cnt++;
            if (timeout_err) err_cnt++;
            if (res_valid) begin
                if (expq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R5 result actual=%h expected=none", res_data);
                end else begin
                    checks++;
                    if (res_data !== 12'(expq[0])) begin
                        errors++;
                        $display("FAIL R5 result actual=%h expected=%h", res_data, 12'(expq[0]));
                    end
                    void'(expq.pop_front());
                end
            end
        end
        pcs = cs_n;
    end

    // cycle-by-cycle reference of the pin waveform
    initial begin : ref_model
        logic [7:0] cur, nxt;
        bit more, tl;
        int lo_n, hi_n;
        logic rdy, rv, er;
        wait (rst_n === 1'b1);
        forever begin
            @(negedge clk);
            expect_cycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
            if (req_valid) begin
                cur = req_cmd;
                tl  = 0;
                do begin
                    more = 0;
                    lo_n = (lo == 0) ? 1 : int'(lo);
                    hi_n = (hi == 0) ? 1 : int'(hi);
                    for (int s = 0; s < 24 && !more; s++) begin
                        logic b;
                        b = (s < 8) ? cur[7 - s] : 1'b0;
                        for (int i = 0; i < lo_n; i++) begin
                            @(negedge clk);
                            expect_cycle(1'b0, 1'b0, b, 1'b0, 1'b0, 1'b0);
                        end
                        for (int i = 0; i < hi_n; i++) begin
                            @(negedge clk);
                            rdy = ovl && (s == 15) && (i == hi_n - 1);
                            rv  = (i == 0) && ((s == 20) || (tl && s == 4));
                            er  = (i == 0) && chk_en && (lim != 0) &&
                                  (busy_len >= int'(lim)) && (s == 7 + int'(lim));
                            expect_cycle(1'b0, 1'b1, b, rdy, rv, er);
                            if (rdy && req_valid) begin
                                more = 1;
                                nxt  = req_cmd;
                            end
                        end
                    end
                    if (more) begin
                        cur = nxt;
                        tl  = 1;
                    end
                end while (more);
            end
        end
    end

    task automatic wait_idle();
        int n;
        while (cmdq.size() != 0) @(negedge clk);
        n = 0;
        while (n < 4) begin
            @(negedge clk);
            n = (cs_n === 1'b1) ? n + 1 : 0;
        end
    endtask

    task automatic run(input int e_low, input int e_rise, input int e_err, input string tag);
        int c0, r0, t0;
        c0 = cs_low_cnt; r0 = rise_cnt; t0 = err_cnt;
        wait_idle();
        cmp_int(cs_low_cnt - c0, e_low, {tag, " cycles with select low"});
        cmp_int(rise_cnt - r0, e_rise, {tag, " select releases"});
        cmp_int(err_cnt - t0, e_err, {tag, " timeout pulses"});
    endtask

    initial begin
        rst_n = 1'b0;
        lo = 8'd2; hi = 8'd2; ovl = 1'b0; chk_en = 1'b0; lim = 8'd4;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp(cs_n, 1'b1, "R1 reset chip select");
        cmp(sclk, 1'b0, "R1 reset serial clock");
        cmp(mosi, 1'b0, "R1 reset data-in");
        cmp(res_valid, 1'b0, "R1 reset done strobe");
        cmp(timeout_err, 1'b0, "R1 reset timeout");
        @(posedge clk); #1 rst_n = 1'b1;

        // R2 plain frame
        cmdq.push_back(8'h93);
        run(96, 1, 0, "R2 plain frame");

        // R10 second request held until idle
        lo = 8'd1; hi = 8'd1;
        cmdq.push_back(8'hD4); cmdq.push_back(8'hA5);
        run(96, 2, 0, "R10 held request");

        // R3 asymmetric phases
        lo = 8'd3; hi = 8'd1;
        cmdq.push_back(8'h80);
        run(96, 1, 0, "R3 asymmetric phases");

        // R3 zero phase counts act as one
        lo = 8'd0; hi = 8'd0;
        cmdq.push_back(8'hC7);
        run(48, 1, 0, "R3 zero phase count");

        // R7 overlapped conversions
        ovl = 1'b1; lo = 8'd1; hi = 8'd2;
        cmdq.push_back(8'h91); cmdq.push_back(8'hC2); cmdq.push_back(8'hB7);
        run(168, 1, 0, "R7 overlapped chain");

        // R8 overlap mode, nothing pending
        lo = 8'd2; hi = 8'd1;
        cmdq.push_back(8'hE0);
        run(72, 1, 0, "R8 lone overlapped request");

        // R9 busy watchdog
        ovl = 1'b0; lo = 8'd1; hi = 8'd1; chk_en = 1'b1; lim = 8'd4;
        busy_len = 3;
        cmdq.push_back(8'h90);
        run(48, 1, 0, "R9 busy under limit");
        busy_len = 6;
        cmdq.push_back(8'hD0);
        run(48, 1, 1, "R9 busy over limit");
        lim = 8'd0;
        cmdq.push_back(8'hD1);
        run(48, 1, 0, "R9 zero limit");
        chk_en = 1'b0; lim = 8'd4;
        cmdq.push_back(8'h95);
        run(48, 1, 0, "R9 check disabled");

        // R9 with R7: watchdog across overlapped conversions
        chk_en = 1'b1; lim = 8'd2; busy_len = 8; ovl = 1'b1;
        cmdq.push_back(8'hA1); cmdq.push_back(8'hF3);
        run(80, 1, 2, "R9 overlapped watchdog");

        cmp_int(expq.size(), 0, "R5 results outstanding");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog R2 actual=hung expected=idle");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule